// File: doc/BRIEF.md
# Edge-Triggered Interrupt Input Port

The block watches a port of input pins and turns selected transitions on them into interrupt requests. Each pin first passes through a two-flop synchroniser. A transition is then detected on the synchronised value. Each bit has its own polarity control, which picks either a low-to-high or a high-to-low transition. A detected transition sets a sticky per-bit flag. The flag stays set until software writes it.

A small register bus reads and writes four registers: the synchronised pin values, the polarity controls, the per-bit enables and the flags. Software may write any flag value. This lets it clear stale flags before it turns on enables, or set a flag to test the handler. A single request output is raised while the global-enable input is high and at least one bit has both its flag and its enable set.

Top module: `gpio_edge_irq`

## Requirements
- R1: With polarity bit 0, a low-to-high change on a pin sets that bit's flag three clock edges after the pin is first sampled. A high-to-low change leaves the flag untouched.
- R2: With polarity bit 1, a high-to-low change on a pin sets that bit's flag three clock edges after the pin is first sampled. A low-to-high change leaves the flag untouched.
- R3: `irq` equals `irq_global_en` AND the OR over all bits of (flag AND enable).
- R4: A set flag remains set until a bus write to the flag register clears it. A later transition of either direction does not clear it.
- R5: A bus write to the flag register (address 3) loads the written value exactly, setting or clearing any bit.
- R6: A read of address 0 returns the pins after the two-flop synchroniser. Writes to address 0 have no effect.
- R7: If a transition is detected in the same cycle as a flag-register write that clears that bit, the bit ends up set.
- R8: Writing the polarity register (address 1) never by itself sets a flag.
- R9: After reset, the polarity (address 1), enable (address 2) and flag (address 3) registers read 0, and `irq` is 0. Reads are combinational on `bus_addr`. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 8 | Asynchronous input pins |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register address: 0 pins, 1 polarity, 2 enable, 3 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_global_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A flag register stuck at a wrong value shows up on `irq` in the same cycle for any enabled bit. It also shows on a flag read one cycle after the write or transition that should have moved it. A wrong synchroniser depth or a wrong edge comparison shifts or drops flag setting: the flag is missing, or set for the wrong polarity, on the read taken three edges after the pin change. A wrong priority between a write and a transition shows as a flag that reads 0 right after the collision cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PORT_W_DEF = 8;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PINS  = 2'd0,
        REG_POL   = 2'd1,
        REG_MASK  = 2'd2,
        REG_FLAGS = 2'd3
    } reg_sel_e;

    // polarity: 0 = low-to-high, 1 = high-to-low
    function automatic logic edge_seen(input logic now_v, input logic before_v,
                                       input logic falling);
        return falling ? (before_v & ~now_v) : (now_v & ~before_v);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    input  logic [N-1:0] polarity,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar b = 0; b < N; b++) begin : g_bit
        assign hit[b] = edge_seen(level[b], prev_q[b], polarity[b]);
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      level,
    input  logic [N-1:0]      hit,
    output logic [N-1:0]      polarity,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      flags
);
    logic     wr_en;
    reg_sel_e sel;
    logic     pol_we, mask_we, flag_we;
    logic [N-1:0] pol_q, mask_q, flag_q, flag_d;

    assign wr_en   = bus_sel & bus_wr;
    assign sel     = reg_sel_e'(bus_addr);
    assign pol_we  = wr_en && (sel == REG_POL);
    assign mask_we = wr_en && (sel == REG_MASK);
    assign flag_we = wr_en && (sel == REG_FLAGS);

    // a detected transition overrides a clearing write
    always_comb begin
        flag_d = flag_we ? bus_wdata : flag_q;
        flag_d = flag_d | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= '0;
            mask_q <= '0;
            flag_q <= '0;
        end else begin
            if (pol_we)  pol_q  <= bus_wdata;
            if (mask_we) mask_q <= bus_wdata;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        unique case (sel)
            REG_PINS:  bus_rdata = level;
            REG_POL:   bus_rdata = pol_q;
            REG_MASK:  bus_rdata = mask_q;
            REG_FLAGS: bus_rdata = flag_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign polarity = pol_q;
    assign mask     = mask_q;
    assign flags    = flag_q;

    for (genvar b = 0; b < N; b++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flag_q[b] && !flag_we) |=> flag_q[b]); // R4
        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
            hit[b] |=> flag_q[b]); // R7
        AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
            (flag_we && !hit[b]) |=> (flag_q[b] == $past(bus_wdata[b]))); // R5
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
            (!flag_q[b] && !flag_we && !hit[b]) |=> !flag_q[b]); // R8
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int N          = PORT_W_DEF,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pins,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic              irq_global_en,
    output logic              irq
);
    logic [N-1:0] level, hit, polarity, mask, flags;

    gpio_sync #(.N(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .async_in(pins), .sync_out(level)
    );

    gpio_edge #(.N(N)) u_edge (
        .clk(clk), .rst(rst), .level(level), .polarity(polarity), .hit(hit)
    );

    gpio_regs #(.N(N)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .level(level), .hit(hit),
        .polarity(polarity), .mask(mask), .flags(flags)
    );

    assign irq = irq_global_en & |(flags & mask);

    AST_IRQ_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        !irq_global_en |-> !irq); // R3
    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & mask) != '0)); // R3
endmodule

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] pins = '0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_global_en = 0;
    logic       irq;
    int errors = 0, total = 0;

    always #10 clk = ~clk;

    gpio_edge_irq u_gpio_edge_irq (
        .clk(clk), .rst(rst), .pins(pins),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_global_en(irq_global_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        rd(2'd1, v); chk("R9 polarity reset", v, 8'h00);
        rd(2'd2, v); chk("R9 enable reset", v, 8'h00);
        rd(2'd3, v); chk("R9 flags reset", v, 8'h00);
        chk("R9 irq reset", {7'd0, irq}, 8'h00);

        // per-bit, per-polarity sweep
        for (int b = 0; b < 8; b++) begin
            for (int pol = 0; pol < 2; pol++) begin
                wr(2'd1, pol ? (8'h01 << b) : 8'h00);
                wr(2'd3, 8'h00);
                if (pol == 1) begin
                    pins = 8'h01 << b; settle();
                    rd(2'd0, v); chk("R6 pin read", v, 8'h01 << b);
                    rd(2'd3, v); chk("R2 rising ignored", v, 8'h00);
                    pins = 8'h00;
                    @(negedge clk); @(negedge clk);
                    rd(2'd3, v); chk("R2 not before third edge", v, 8'h00);
                    @(negedge clk);
                    rd(2'd3, v); chk("R2 falling sets flag", v, 8'h01 << b);
                end else begin
                    pins = 8'h01 << b;
                    @(negedge clk); @(negedge clk);
                    rd(2'd3, v); chk("R1 not before third edge", v, 8'h00);
                    @(negedge clk);
                    rd(2'd3, v); chk("R1 rising sets flag", v, 8'h01 << b);
                    pins = 8'h00; settle();
                    rd(2'd3, v); chk("R4 flag stays after falling", v, 8'h01 << b);
                end
                wr(2'd3, 8'h00);
                rd(2'd3, v); chk("R5 clear by write", v, 8'h00);
            end
        end

        // R5 arbitrary flag load
        wr(2'd3, 8'hA5); rd(2'd3, v); chk("R5 load A5", v, 8'hA5);
        wr(2'd3, 8'h5A); rd(2'd3, v); chk("R5 load 5A", v, 8'h5A);

        // R8 polarity change alone sets nothing; R6 pin writes ignored
        wr(2'd1, 8'h00);
        pins = 8'hFF; settle();
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFF); settle();
        wr(2'd1, 8'h00); settle();
        rd(2'd3, v); chk("R8 polarity toggle", v, 8'h00);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R6 pin write ignored", v, 8'hFF);

        // R7 transition and clearing write collide
        wr(2'd1, 8'hFF); wr(2'd3, 8'h00);
        @(negedge clk); pins = 8'hF7;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 8'h00;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        rd(2'd3, v); chk("R7 edge beats clear", v, 8'h08);
        pins = 8'h00; settle();

        // R3 request sweep over all flag values
        wr(2'd1, 8'h00);
        for (int f = 0; f < 256; f++) begin
            logic [7:0] e;
            e = 8'(f * 37 + 5);
            wr(2'd3, 8'(f));
            wr(2'd2, e);
            for (int g = 0; g < 2; g++) begin
                irq_global_en = g[0];
                #1 chk("R3 request", {7'd0, irq},
                       {7'd0, g[0] & ((8'(f) & e) != 8'h00)});
            end
            irq_global_en = 0;
        end

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule